// File: doc/BRIEF.md
# Sequencer Control and Status Register Unit

This block holds the configuration and observation registers of a processor's program sequencer. Software reaches them over a simple synchronous register bus with an address, a write strobe with write data, and a read strobe. The read data comes back one clock later. A single control register can be reached at three addresses. One address overwrites it. A second ORs the written word into it, so software can raise chosen bits without a read-modify-write. A third ANDs the written word into it, so a zero in the data drops that bit and a one leaves it alone. That third alias is the reverse of the usual write-one-to-clear convention.

A status register follows a live status vector from the sequencer on every clock and ignores bus writes. A static-flag register takes a snapshot of a condition vector whenever a capture strobe is high. It keeps that snapshot after the live conditions move on, so the value can be tested later. Software may also load the flag register directly over the bus. The meaning of individual control and status bits is outside this block.

Top module: `seqr_ctl_regs`

## Requirements
- R1: In the cycles after a reset, the control register reads 0x0100 (zero-extended to the data width), the flag register reads zero, the read data port is zero, and the status register holds 0xFF00 for as long as reset is asserted.
- R2: A write to word address 0 replaces the control register with the write data.
- R3: A write to word address 1 makes the control register equal to its old value ORed with the write data, so a 1 sets a bit and a 0 keeps it.
- R4: A write to word address 2 makes the control register equal to its old value ANDed with the write data, so a 0 clears a bit and a 1 keeps it.
- R5: A read of address 0, 1 or 2 returns the current control register value.
- R6: The status register at address 3 ignores bus writes. Outside reset it loads the status input on every clock, and a read of it returns the value loaded on the previous clock.
- R7: The flag register at address 4 loads the condition vector on each clock where the capture strobe is high, and keeps its value while the strobe is low. It reads back zero-extended in the low COND_W bits.
- R8: A bus write to address 4 loads the low COND_W bits of the write data into the flag register, and it wins over a capture in the same cycle.
- R9: Read data is registered. It appears on the clock after the read strobe and shows the register contents from before any write in that same cycle. It holds its value in cycles without a read.
- R10: Addresses 5 to 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| stat_in | input | DATA_W | Live status vector from the sequencer |
| cond_cap | input | 1 | Condition capture strobe |
| cond_in | input | COND_W | Live condition vector |

## Verification
The bench builds the unit with DATA_W = 16, COND_W = 8 and ADDR_W = 3. At this size every control bit can be set and cleared on its own through both aliases, and all 256 condition patterns can be captured and read back. All eight addresses, including the three unmapped ones, can be written and read. The narrow flag width also makes the zero-extension of flag reads visible in the upper byte.

// File: rtl/seqr_pkg.sv
// Shared definitions for the sequencer register unit: word-address map and
// the one-hot-free register select code produced by the address decoder.
package seqr_pkg;

    localparam int OFF_DIRECT = 0;
    localparam int OFF_SET    = 1;
    localparam int OFF_CLR    = 2;
    localparam int OFF_STAT   = 3;
    localparam int OFF_FLAG   = 4;

    typedef enum logic [2:0] {
        SEL_DIRECT = 3'd0,
        SEL_SET    = 3'd1,
        SEL_CLR    = 3'd2,
        SEL_STAT   = 3'd3,
        SEL_FLAG   = 3'd4,
        SEL_NONE   = 3'd7
    } seqr_sel_e;

endpackage

// File: rtl/seqr_decode.sv
// Address decoder: maps a bus word address onto a register select code.
// Assumes ADDR_W is wide enough to hold every offset in seqr_pkg.
module seqr_decode
    import seqr_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output seqr_sel_e         sel
);

    // Combinational lookup of the register addressed this cycle.
    always_comb begin
        if (addr == ADDR_W'(OFF_DIRECT))      sel = SEL_DIRECT;
        else if (addr == ADDR_W'(OFF_SET))    sel = SEL_SET;
        else if (addr == ADDR_W'(OFF_CLR))    sel = SEL_CLR;
        else if (addr == ADDR_W'(OFF_STAT))   sel = SEL_STAT;
        else if (addr == ADDR_W'(OFF_FLAG))   sel = SEL_FLAG;
        else                                  sel = SEL_NONE;
    end

endmodule

// File: rtl/seqr_ctl_reg.sv
// Control register with three write views: replace, OR-in and AND-in.
// Assumes at most one write per cycle; sel comes from seqr_decode.
module seqr_ctl_reg
    import seqr_pkg::*;
#(
    parameter int              DATA_W  = 32,
    parameter logic [DATA_W-1:0] RST_VAL = DATA_W'('h0100)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  seqr_sel_e         sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctl_q
);

    logic [DATA_W-1:0] ctl_d;

    // Next value: pick the merge rule of the alias being written.
    always_comb begin
        ctl_d = ctl_q;
        if (wr) begin
            case (sel)
                SEL_DIRECT: ctl_d = wdata;
                SEL_SET:    ctl_d = ctl_q | wdata;
                SEL_CLR:    ctl_d = ctl_q & wdata;
                default:    ctl_d = ctl_q;
            endcase
        end
    end

    // State update with synchronous reset to the configured reset word.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= RST_VAL;
        else        ctl_q <= ctl_d;
    end

endmodule

// File: rtl/seqr_obs_regs.sv
// Observation registers: a status copy that tracks the live status input
// each clock, and a static-flag snapshot of the condition vector.
// Assumes COND_W <= DATA_W; bus writes win over capture on the flags.
module seqr_obs_regs
    import seqr_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter int                COND_W   = 32,
    parameter logic [DATA_W-1:0] STAT_RST = DATA_W'('hFF00)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  seqr_sel_e         sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] stat_in,
    input  logic              cond_cap,
    input  logic [COND_W-1:0] cond_in,
    output logic [DATA_W-1:0] stat_q,
    output logic [COND_W-1:0] flag_q
);

    // Status follows the live input; bus writes never reach it.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= STAT_RST;
        else        stat_q <= stat_in;
    end

    // Flag snapshot: software load first, then condition capture.
    always_ff @(posedge clk) begin
        if (!rst_n)                      flag_q <= '0;
        else if (wr && sel == SEL_FLAG)  flag_q <= wdata[COND_W-1:0];
        else if (cond_cap)               flag_q <= cond_in;
    end

endmodule

// File: rtl/seqr_rdback.sv
// Registered read-back multiplexer. Data is sampled from the register
// outputs before any same-cycle write lands, and held when no read occurs.
module seqr_rdback
    import seqr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int COND_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  seqr_sel_e         sel,
    input  logic [DATA_W-1:0] ctl_q,
    input  logic [DATA_W-1:0] stat_q,
    input  logic [COND_W-1:0] flag_q,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] flag_ext;
    logic [DATA_W-1:0] rd_mux;

    // Zero-extend the flag snapshot to the bus width.
    always_comb begin
        flag_ext = '0;
        flag_ext[COND_W-1:0] = flag_q;
    end

    // Select the addressed register; unmapped slots give zero.
    always_comb begin
        case (sel)
            SEL_DIRECT, SEL_SET, SEL_CLR: rd_mux = ctl_q;
            SEL_STAT:                     rd_mux = stat_q;
            SEL_FLAG:                     rd_mux = flag_ext;
            default:                      rd_mux = '0;
        endcase
    end

    // Output register, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_mux;
    end

endmodule

// File: rtl/seqr_ctl_regs.sv
// Top of the sequencer register unit: decoder, control register with
// set/clear aliases, status and flag registers, and registered read-back.
// Assumes a single bus master and COND_W <= DATA_W.
module seqr_ctl_regs
    import seqr_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter int                COND_W   = 32,
    parameter int                ADDR_W   = 3,
    parameter logic [DATA_W-1:0] CTL_RST  = DATA_W'('h0100),
    parameter logic [DATA_W-1:0] STAT_RST = DATA_W'('hFF00)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] stat_in,
    input  logic              cond_cap,
    input  logic [COND_W-1:0] cond_in
);

    seqr_sel_e         sel;
    logic [DATA_W-1:0] ctl_q;
    logic [DATA_W-1:0] stat_q;
    logic [COND_W-1:0] flag_q;

    seqr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    seqr_ctl_reg #(.DATA_W(DATA_W), .RST_VAL(CTL_RST)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .ctl_q (ctl_q)
    );

    seqr_obs_regs #(.DATA_W(DATA_W), .COND_W(COND_W), .STAT_RST(STAT_RST)) u_obs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .sel      (sel),
        .wdata    (bus_wdata),
        .stat_in  (stat_in),
        .cond_cap (cond_cap),
        .cond_in  (cond_in),
        .stat_q   (stat_q),
        .flag_q   (flag_q)
    );

    seqr_rdback #(.DATA_W(DATA_W), .COND_W(COND_W)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (bus_rd),
        .sel    (sel),
        .ctl_q  (ctl_q),
        .stat_q (stat_q),
        .flag_q (flag_q),
        .rdata  (bus_rdata)
    );

endmodule

// File: rtl/seqr_ctl_regs_chk.sv
// Property checker for seqr_ctl_regs, attached by bind. Decodes the bus
// address on its own and relates bus activity to the register state.
module seqr_ctl_regs_chk
    import seqr_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter int                COND_W   = 32,
    parameter int                ADDR_W   = 3,
    parameter logic [DATA_W-1:0] CTL_RST  = DATA_W'('h0100),
    parameter logic [DATA_W-1:0] STAT_RST = DATA_W'('hFF00)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] stat_in,
    input logic              cond_cap,
    input logic [COND_W-1:0] cond_in,
    input logic [DATA_W-1:0] ctl_q,
    input logic [DATA_W-1:0] stat_q,
    input logic [COND_W-1:0] flag_q
);

    logic a_dir, a_set, a_clr, a_stat, a_flag, a_none;
    assign a_dir  = bus_addr == ADDR_W'(OFF_DIRECT);
    assign a_set  = bus_addr == ADDR_W'(OFF_SET);
    assign a_clr  = bus_addr == ADDR_W'(OFF_CLR);
    assign a_stat = bus_addr == ADDR_W'(OFF_STAT);
    assign a_flag = bus_addr == ADDR_W'(OFF_FLAG);
    assign a_none = !(a_dir || a_set || a_clr || a_stat || a_flag);

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (ctl_q == CTL_RST && stat_q == STAT_RST && flag_q == '0 && bus_rdata == '0));

    p_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && a_dir |=> ctl_q == $past(bus_wdata));

    p_set_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && a_set |=> ctl_q == ($past(ctl_q) | $past(bus_wdata)));

    p_clr_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && a_clr |=> ctl_q == ($past(ctl_q) & $past(bus_wdata)));

    p_alias_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && (a_dir || a_set || a_clr) |=> bus_rdata == $past(ctl_q));

    p_stat_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> stat_q == $past(stat_in));

    p_flag_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cond_cap && !(bus_wr && a_flag) |=> flag_q == $past(cond_in));

    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_cap && !(bus_wr && a_flag) |=> $stable(flag_q));

    p_flag_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && a_flag |=> flag_q == $past(bus_wdata[COND_W-1:0]));

    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    p_unmapped_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && a_none |=> bus_rdata == '0);

    p_unmapped_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (a_none || a_stat || a_flag) |=> $stable(ctl_q));

endmodule

bind seqr_ctl_regs seqr_ctl_regs_chk #(
    .DATA_W(DATA_W), .COND_W(COND_W), .ADDR_W(ADDR_W),
    .CTL_RST(CTL_RST), .STAT_RST(STAT_RST)
) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .stat_in(stat_in), .cond_cap(cond_cap), .cond_in(cond_in),
    .ctl_q(ctl_q), .stat_q(stat_q), .flag_q(flag_q)
);

// File: tb/test_seqr_ctl_regs.sv
module test_seqr_ctl_regs;

    localparam int DW = 16;
    localparam int CW = 8;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic [DW-1:0] stat_in = 16'h00A5;
    logic          cond_cap = 1'b0;
    logic [CW-1:0] cond_in = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] m_ctl;
    logic [CW-1:0] m_flag;
    logic [DW-1:0] got;

    always #4 clk = ~clk;

    seqr_ctl_regs #(.DATA_W(DW), .COND_W(CW), .ADDR_W(AW)) i_seqr_ctl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .stat_in(stat_in), .cond_cap(cond_cap), .cond_in(cond_in)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, status held at FF00 while reset is low
        repeat (3) @(negedge clk);
        chk("R1 rdata at reset", bus_rdata, 16'h0000);
        bus_addr = 3'd3; bus_rd = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R1 status reset value", bus_rdata, 16'hFF00);
        m_ctl = 16'h0100;
        m_flag = '0;
        bus_read(0, got); chk("R1 control reset", got, m_ctl);
        bus_read(4, got); chk("R1 flag reset", got, 16'h0000);
        bus_read(3, got); chk("R6 status tracks input", got, 16'h00A5);

        // R3: set alias, one bit at a time
        for (int i = 0; i < DW; i++) begin
            bus_write(1, DW'(1) << i);
            m_ctl = m_ctl | (DW'(1) << i);
            bus_read(0, got); chk("R3 set alias bit", got, m_ctl);
        end
        // R4: clear alias, zero in one position each time
        for (int i = 0; i < DW; i++) begin
            bus_write(2, ~(DW'(1) << i));
            m_ctl = m_ctl & ~(DW'(1) << i);
            bus_read(0, got); chk("R4 clear alias bit", got, m_ctl);
        end
        // R2, R3, R4, R5: mixed patterns, read through all three aliases
        for (int i = 0; i < 16; i++) begin
            logic [DW-1:0] p;
            p = DW'(i * 16'h1357) ^ 16'hA5A5;
            bus_write(0, p); m_ctl = p;
            bus_read(i % 3, got); chk("R2 R5 direct write read via alias", got, m_ctl);
            bus_write(1, ~p ^ DW'(i)); m_ctl = m_ctl | (~p ^ DW'(i));
            bus_read((i + 1) % 3, got); chk("R3 R5 set pattern", got, m_ctl);
            bus_write(2, p >> 3); m_ctl = m_ctl & (p >> 3);
            bus_read((i + 2) % 3, got); chk("R4 R5 clear pattern", got, m_ctl);
        end

        // R6: writes to status ignored, value follows stat_in
        @(negedge clk); stat_in = 16'h3C5A;
        bus_write(3, 16'hFFFF);
        bus_read(3, got); chk("R6 status write ignored", got, 16'h3C5A);
        bus_read(0, got); chk("R6 status write leaves control", got, m_ctl);

        // R7: exhaustive capture of condition patterns
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            cond_in = CW'(v); cond_cap = 1'b1;
            @(negedge clk);
            cond_cap = 1'b0; cond_in = ~CW'(v);
            m_flag = CW'(v);
            bus_read(4, got); chk("R7 flag capture", got, {8'h00, m_flag});
        end
        bus_read(4, got); chk("R7 flag holds after input moves", got, {8'h00, m_flag});

        // R8: bus write to flags, and priority over capture
        bus_write(4, 16'hBE5A);
        bus_read(4, got); chk("R8 flag bus write", got, 16'h005A);
        @(negedge clk);
        bus_addr = 3'd4; bus_wdata = 16'h00C3; bus_wr = 1'b1;
        cond_in = 8'h3C; cond_cap = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; cond_cap = 1'b0;
        bus_read(4, got); chk("R8 write beats capture", got, 16'h00C3);

        // R9: read in a write cycle sees old value; rdata holds when idle
        bus_write(0, 16'h1111); m_ctl = 16'h1111;
        @(negedge clk);
        bus_addr = 3'd1; bus_wdata = 16'h2222; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R9 read during write returns old", bus_rdata, 16'h1111);
        m_ctl = 16'h3333;
        repeat (3) @(negedge clk);
        chk("R9 rdata holds without read", bus_rdata, 16'h1111);
        bus_read(2, got); chk("R9 post-write value", got, m_ctl);

        // R10: unmapped addresses
        for (int a = 5; a < 8; a++) begin
            bus_write(a, 16'h0000);
            bus_read(a, got); chk("R10 unmapped reads zero", got, 16'h0000);
            bus_read(0, got); chk("R10 unmapped write no effect", got, m_ctl);
            bus_read(4, got); chk("R10 unmapped write keeps flags", got, 16'h00C3);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule